// File: doc/BRIEF.md
# Word-Serial Uniform Crossover and Mutation Engine

This block produces two offspring bit strings from two parent bit strings that sit in a word-organised chromosome memory. Each bit of a string assigns one circuit cell to a partition: a 1 places the cell in partition 1 and a 0 places it in partition 0. A string spans consecutive memory words. The engine walks the words in ascending order. For each word it reads both parents through a dual-address read port. It then decides at random whether to recombine that word, and writes both children through one write port into a region that the caller picks, normally the other bank.

Recombination is uniform. A fresh random mask chooses, bit by bit, which parent each child inherits from. After that, each child word may have one random bit flipped. The flip is only allowed when it pulls that child's running count of ones toward half of the bits seen so far, which keeps the two partitions close to equal size. A controller starts a run with a one-cycle start pulse and waits for the done pulse.

Top module: `uxm_engine`

## Requirements
- R1: While reset is held, `rd_en_o`, `wr_en_o` and `done_o` are low.
- R2: For word i (counting from 0) there is exactly one read, with `rd_addr1_o` = parent-1 base + i and `rd_addr2_o` = parent-2 base + i. Reads come in ascending word order. Read data is taken in the cycle after `rd_en_o`, and a read never happens in the same cycle as a write.
- R3: For word i, child 1 is written at child-1 base + i. In the very next cycle child 2 is written at child-2 base + i. The first of these two writes comes two cycles after that word's read.
- R4: Each rate decision draws an 8-bit uniform value r and applies the operation when r < rate, or always when rate = 255, so a rate of 0 never applies it. With both rates 0, every child word equals the same word of its own parent (child 1 from parent 1, child 2 from parent 2).
- R5: When crossover applies, child 1 takes the parent-1 bit where the mask bit is 1 and the parent-2 bit where it is 0, and child 2 takes the other one. Without mutation, the bitwise AND and OR of the two child words therefore equal the AND and OR of the two parent words. The mask is drawn anew for every word, so with crossover rate 255 over 16 words of all-ones parent 1 and all-zeros parent 2, at least one child-1 word differs from parent 1.
- R6: With mutation rate 0 no bit is flipped. The children are exactly the result of the crossover step.
- R7: For each child, define t as the ones-minus-zeros total over the words of that child already written in this run, plus the ones-minus-zeros of the current word before mutation. Mutation changes at most one bit of a word. It turns a 1 into 0 only when t > 0, turns a 0 into 1 only when t < 0, and changes nothing when t = 0.
- R8: With mutation rate 255 a random bit of every word is tested. A child word that is all ones before mutation, with t > 0, loses exactly one 1. An all-zeros word with t < 0 gains exactly one 1.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last child-2 write. A length of 0 gives done in the cycle after start, with no reads or writes.
- R10: All inputs for a run are captured on the accepted start. A start pulse while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a run when idle |
| par1_base_i | input | ADDR_W | First word address of parent 1 |
| par2_base_i | input | ADDR_W | First word address of parent 2 |
| kid1_base_i | input | ADDR_W | First word address for child 1 |
| kid2_base_i | input | ADDR_W | First word address for child 2 |
| len_words_i | input | LEN_W | String length in memory words |
| xover_rate_i | input | 8 | Crossover probability, value/255 |
| mut_rate_i | input | 8 | Mutation probability, value/255 |
| rd_en_o | output | 1 | Read strobe for both parent addresses |
| rd_addr1_o | output | ADDR_W | Parent-1 word address |
| rd_addr2_o | output | ADDR_W | Parent-2 word address |
| rd_data1_i | input | DATA_W | Parent-1 word, valid the cycle after the strobe |
| rd_data2_i | input | DATA_W | Parent-2 word, valid the cycle after the strobe |
| wr_en_o | output | 1 | Child word write strobe |
| wr_addr_o | output | ADDR_W | Child word address |
| wr_data_o | output | DATA_W | Child word data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The mask and the mutated bit come from internal generators and cannot be steered from the ports. The stimulus therefore picks parent words that make the outcome certain whatever random values are drawn. All-ones against all-zeros parents make every change visible. Uniform all-ones runs keep the running imbalance positive, so every tested bit must flip. A half-ones single word forces t = 0, so no flip is allowed. Mixed runs are checked against the direction rule, using an imbalance the bench accumulates from the words actually written.

// File: rtl/uxm_pkg.sv
package uxm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_WR1,
      ST_WR2,
      ST_DONE
   } uxm_state_e;

   // rate 255 means always; otherwise apply when draw < rate
   function automatic logic rate_hit(input logic [7:0] draw, input logic [7:0] rate);
      return (rate == 8'hFF) || (draw < rate);
   endfunction

   // distinct non-zero-ish seed per random lane
   function automatic logic [31:0] lane_seed(input logic [31:0] base, input int lane);
      logic [31:0] s;
      s = base ^ (32'h9E37_79B9 * 32'(lane + 1));
      if (s == 32'h0) s = 32'h0000_0001;
      return s;
   endfunction

endpackage

// File: rtl/uxm_lfsr_lane.sv
module uxm_lfsr_lane #(
   parameter logic [31:0] SEED = 32'h0000_0001,
   parameter logic [31:0] TAPS = 32'h8020_0003
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] state_o
);

   if (SEED == 32'h0) begin : g_bad_seed
      $error("uxm_lfsr_lane: SEED must be non-zero");
   end

   logic [31:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : 32'h0);
   end

   assign state_o = state_q;

endmodule

// File: rtl/uxm_rng.sv
module uxm_rng
   import uxm_pkg::*;
#(
   parameter int          OUT_W = 32,
   parameter logic [31:0] SEED  = 32'h5A17_C3E9
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd_o
);

   localparam int NLANE = (OUT_W + 31) / 32;
   localparam int POOLW = NLANE * 32;
   localparam int SPARE = POOLW - OUT_W;

   if (OUT_W < 1) begin : g_bad_width
      $error("uxm_rng: OUT_W must be positive");
   end

   logic [POOLW-1:0] pool;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      uxm_lfsr_lane #(
         .SEED (lane_seed(SEED, g))
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .state_o (pool[g*32 +: 32])
      );
   end

   if (SPARE > 0) begin : g_fold
      assign rnd_o = pool[OUT_W-1:0] ^ OUT_W'(pool[POOLW-1:OUT_W]);
   end else begin : g_exact
      assign rnd_o = pool[OUT_W-1:0];
   end

endmodule

// File: rtl/uxm_mutate.sv
module uxm_mutate #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3,
   parameter int BAL_W  = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [DATA_W-1:0]       word_i,
   input  logic [IDX_W-1:0]        bit_i,
   input  logic                    apply_i,
   input  logic signed [BAL_W-1:0] bal_i,
   output logic [DATA_W-1:0]       word_o,
   output logic signed [BAL_W-1:0] delta_o
);

   localparam int CNT_W = IDX_W + 1;

   if ((1 << IDX_W) != DATA_W) begin : g_bad_idx
      $error("uxm_mutate: IDX_W must be log2(DATA_W)");
   end

   logic [CNT_W-1:0]        ones;
   logic signed [BAL_W-1:0] w_imb;
   logic signed [BAL_W-1:0] t_imb;
   logic signed [BAL_W-1:0] step;
   logic                    pick;
   logic                    flip;

   always_comb begin
      ones = '0;
      for (int b = 0; b < DATA_W; b++) ones = ones + CNT_W'(word_i[b]);
   end

   assign w_imb  = $signed(BAL_W'({ones, 1'b0})) - $signed(BAL_W'(DATA_W));
   assign t_imb  = bal_i + w_imb;
   assign pick   = word_i[bit_i];
   assign flip   = apply_i && (pick ? (t_imb > 0) : (t_imb < 0));
   assign step   = pick ? -$signed(BAL_W'(2)) : $signed(BAL_W'(2));
   assign word_o = flip ? (word_i ^ (DATA_W'(1) << bit_i)) : word_i;
   assign delta_o = flip ? (w_imb + step) : w_imb;

   p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |-> (word_o == word_i));

   p_single_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(word_o ^ word_i) <= 1);

   p_flip_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_o != word_i) |-> ((t_imb > 0 && delta_o < w_imb) || (t_imb < 0 && delta_o > w_imb)));

endmodule

// File: rtl/uxm_engine.sv
module uxm_engine
   import uxm_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter int          ADDR_W = 8,
   parameter int          LEN_W  = 8,
   parameter logic [31:0] SEED   = 32'h5A17_C3E9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] par1_base_i,
   input  logic [ADDR_W-1:0] par2_base_i,
   input  logic [ADDR_W-1:0] kid1_base_i,
   input  logic [ADDR_W-1:0] kid2_base_i,
   input  logic [LEN_W-1:0]  len_words_i,
   input  logic [7:0]        xover_rate_i,
   input  logic [7:0]        mut_rate_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr1_o,
   output logic [ADDR_W-1:0] rd_addr2_o,
   input  logic [DATA_W-1:0] rd_data1_i,
   input  logic [DATA_W-1:0] rd_data2_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              done_o
);

   localparam int IDX_W = $clog2(DATA_W);
   localparam int BAL_W = LEN_W + IDX_W + 3;
   localparam int RND_W = DATA_W + 16 + 2 * IDX_W;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("uxm_engine: DATA_W must be a power of two, at least 8");
   end
   if (LEN_W < 1 || ADDR_W < LEN_W) begin : g_bad_addr
      $error("uxm_engine: need 1 <= LEN_W <= ADDR_W");
   end

   // ---------------- random source ----------------
   logic [RND_W-1:0] rnd;

   uxm_rng #(
      .OUT_W (RND_W),
      .SEED  (SEED)
   ) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd_o (rnd)
   );

   logic [DATA_W-1:0] rnd_mask;
   logic [7:0]        rnd_xo;
   logic [7:0]        rnd_mu;
   logic [IDX_W-1:0]  mut_bit [2];

   assign rnd_mask   = rnd[DATA_W-1:0];
   assign rnd_xo     = rnd[DATA_W +: 8];
   assign rnd_mu     = rnd[DATA_W+8 +: 8];
   assign mut_bit[0] = rnd[DATA_W+16 +: IDX_W];
   assign mut_bit[1] = rnd[DATA_W+16+IDX_W +: IDX_W];

   // ---------------- run state ----------------
   uxm_state_e        state_q;
   logic [LEN_W-1:0]  idx_q;
   logic [LEN_W-1:0]  len_q;
   logic [ADDR_W-1:0] p1b_q, p2b_q, k1b_q, k2b_q;
   logic [7:0]        xrate_q, mrate_q;
   logic [DATA_W-1:0] kid_q [2];
   logic signed [BAL_W-1:0] bal_q [2];

   // ---------------- crossover ----------------
   logic              xo_hit;
   logic              mu_hit;
   logic [DATA_W-1:0] sel_mask;
   logic [DATA_W-1:0] xo_word  [2];
   logic [DATA_W-1:0] mut_word [2];
   logic signed [BAL_W-1:0] mut_delta [2];

   assign xo_hit     = rate_hit(rnd_xo, xrate_q);
   assign mu_hit     = rate_hit(rnd_mu, mrate_q);
   assign sel_mask   = xo_hit ? rnd_mask : {DATA_W{1'b1}};
   assign xo_word[0] = (sel_mask & rd_data1_i) | (~sel_mask & rd_data2_i);
   assign xo_word[1] = (sel_mask & rd_data2_i) | (~sel_mask & rd_data1_i);

   for (genvar k = 0; k < 2; k++) begin : g_kid
      uxm_mutate #(
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W),
         .BAL_W  (BAL_W)
      ) u_mut (
         .clk     (clk),
         .rst_n   (rst_n),
         .word_i  (xo_word[k]),
         .bit_i   (mut_bit[k]),
         .apply_i (mu_hit),
         .bal_i   (bal_q[k]),
         .word_o  (mut_word[k]),
         .delta_o (mut_delta[k])
      );
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         len_q   <= '0;
         p1b_q   <= '0;
         p2b_q   <= '0;
         k1b_q   <= '0;
         k2b_q   <= '0;
         xrate_q <= '0;
         mrate_q <= '0;
         for (int k = 0; k < 2; k++) begin
            kid_q[k] <= '0;
            bal_q[k] <= '0;
         end
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  idx_q   <= '0;
                  len_q   <= len_words_i;
                  p1b_q   <= par1_base_i;
                  p2b_q   <= par2_base_i;
                  k1b_q   <= kid1_base_i;
                  k2b_q   <= kid2_base_i;
                  xrate_q <= xover_rate_i;
                  mrate_q <= mut_rate_i;
                  for (int k = 0; k < 2; k++) bal_q[k] <= '0;
                  state_q <= (len_words_i == '0) ? ST_DONE : ST_READ;
               end
            end
            ST_READ: state_q <= ST_WAIT;
            ST_WAIT: begin
               for (int k = 0; k < 2; k++) begin
                  kid_q[k] <= mut_word[k];
                  bal_q[k] <= bal_q[k] + mut_delta[k];
               end
               state_q <= ST_WR1;
            end
            ST_WR1: state_q <= ST_WR2;
            ST_WR2: begin
               if (idx_q == len_q - LEN_W'(1)) begin
                  state_q <= ST_DONE;
               end else begin
                  idx_q   <= idx_q + LEN_W'(1);
                  state_q <= ST_READ;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- memory side ----------------
   assign rd_en_o    = (state_q == ST_READ);
   assign rd_addr1_o = p1b_q + ADDR_W'(idx_q);
   assign rd_addr2_o = p2b_q + ADDR_W'(idx_q);
   assign wr_en_o    = (state_q == ST_WR1) || (state_q == ST_WR2);
   assign wr_addr_o  = (state_q == ST_WR1) ? (k1b_q + ADDR_W'(idx_q)) : (k2b_q + ADDR_W'(idx_q));
   assign wr_data_o  = (state_q == ST_WR1) ? kid_q[0] : kid_q[1];
   assign done_o     = (state_q == ST_DONE);

   // ---------------- assertions ----------------
   p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> !wr_en_o);

   p_rd_to_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |=> ##1 wr_en_o);

   p_wr_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en_o) |=> wr_en_o);

   p_wr_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(wr_en_o)) |=> !wr_en_o);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start_i) |=> $stable(p1b_q) && $stable(len_q));

endmodule

// File: tb/uxm_engine_tb_top.sv
module uxm_engine_tb_top;

   localparam int DW = 8;
   localparam int AW = 8;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [AW-1:0] p1b_in, p2b_in, k1b_in, k2b_in;
   logic [LW-1:0] len_in;
   logic [7:0]    xr_in, mr_in;
   logic          rd_en;
   logic [AW-1:0] rd_addr1, rd_addr2;
   logic [DW-1:0] rd_data1 = '0, rd_data2 = '0;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          done;

   always #10 clk = ~clk;

   uxm_engine #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .par1_base_i(p1b_in), .par2_base_i(p2b_in),
      .kid1_base_i(k1b_in), .kid2_base_i(k2b_in),
      .len_words_i(len_in), .xover_rate_i(xr_in), .mut_rate_i(mr_in),
      .rd_en_o(rd_en), .rd_addr1_o(rd_addr1), .rd_addr2_o(rd_addr2),
      .rd_data1_i(rd_data1), .rd_data2_i(rd_data2),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .done_o(done)
   );

   logic [DW-1:0] mem [0:255];

   always @(posedge clk) begin
      if (rd_en) begin
         rd_data1 <= mem[rd_addr1];
         rd_data2 <= mem[rd_addr2];
      end
   end

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      logic [AW-1:0] addr;
      int            kid;
      int            word;
   } exp_t;
   exp_t sbq[$];

   logic [AW-1:0] j_p1b, j_p2b, j_k1b, j_k2b;
   logic [7:0]    j_xr, j_mr;
   int            j_len = 0;
   int            rd_idx = 0;
   int            bal[2];
   int            start_cyc = 0;
   int            last_wr = 0;
   int            done_cnt = 0;
   int            diff_words = 0;
   logic [DW-1:0] kid1_word;

   task automatic check_data(input int kid, input int w, input logic [DW-1:0] data);
      logic [DW-1:0] p1, p2, base, diff;
      int ones, t;
      p1   = mem[AW'(j_p1b + w)];
      p2   = mem[AW'(j_p2b + w)];
      base = (kid == 0) ? p1 : p2;
      if (j_xr == 8'd0 && j_mr == 8'd0)
         chk(data == base, "R4 R6 copy", data, base);
      if (j_mr == 8'd0 && kid == 0) begin
         kid1_word = data;
         if (data != p1) diff_words++;
      end
      if (j_mr == 8'd0 && kid == 1)
         chk(((kid1_word & data) == (p1 & p2)) && ((kid1_word | data) == (p1 | p2)),
             "R5 bit pairs", {kid1_word, data}, {p1, p2});
      if (j_xr == 8'd0 && j_mr == 8'hFF) begin
         diff = data ^ base;
         ones = $countones(diff);
         t    = bal[kid] + 2 * $countones(base) - DW;
         chk(ones <= 1, "R7 one bit", data, base);
         if (ones == 1)
            chk(((base & diff) != '0) ? (t > 0) : (t < 0), "R7 direction", data, base);
         if (base == {DW{1'b1}} && t > 0)
            chk(ones == 1, "R8 forced clear", data, base);
         if (base == '0 && t < 0)
            chk(ones == 1, "R8 forced set", data, base);
      end
      bal[kid] += 2 * $countones(data) - DW;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_en) begin
            chk(rd_addr1 == AW'(j_p1b + rd_idx) && rd_addr2 == AW'(j_p2b + rd_idx),
                "R2 read addr", rd_addr1, AW'(j_p1b + rd_idx));
            chk(!wr_en, "R2 no overlap", wr_en, 0);
            rd_idx++;
         end
         if (wr_en) begin
            if (sbq.size() == 0) begin
               chk(1'b0, "R3 unexpected write", wr_addr, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(wr_addr == e.addr, "R3 write addr", wr_addr, e.addr);
               check_data(e.kid, e.word, wr_data);
               mem[wr_addr] = wr_data;
               last_wr = cyc;
            end
         end
         if (done) begin
            done_cnt++;
            chk(sbq.size() == 0, "R9 writes pending", sbq.size(), 0);
            chk(rd_idx == j_len, "R2 read count", rd_idx, j_len);
            if (j_len > 0) chk(cyc == last_wr + 1, "R9 done timing", cyc, last_wr + 1);
            else           chk(cyc == start_cyc + 1, "R9 empty run", cyc, start_cyc + 1);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 30000) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic run_job(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                          input logic [AW-1:0] c1, input logic [AW-1:0] c2,
                          input int len, input logic [7:0] xr, input logic [7:0] mr,
                          input bit restart_mid);
      int d0;
      j_p1b = a1; j_p2b = a2; j_k1b = c1; j_k2b = c2;
      j_len = len; j_xr = xr; j_mr = mr;
      rd_idx = 0; bal[0] = 0; bal[1] = 0; diff_words = 0;
      for (int w = 0; w < len; w++) begin
         sbq.push_back('{AW'(c1 + w), 0, w});
         sbq.push_back('{AW'(c2 + w), 1, w});
      end
      d0 = done_cnt;
      @(negedge clk);
      p1b_in = a1; p2b_in = a2; k1b_in = c1; k2b_in = c2;
      len_in = LW'(len); xr_in = xr; mr_in = mr;
      start = 1'b1;
      start_cyc = cyc;
      @(negedge clk);
      start = 1'b0;
      if (restart_mid) begin
         // R10: a second start mid-run with other settings must be ignored
         repeat (3) @(negedge clk);
         p1b_in = 8'h40; p2b_in = 8'h50; k1b_in = 8'hC0; k2b_in = 8'hD0;
         len_in = LW'(2); xr_in = 8'hFF; mr_in = 8'hFF;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (done_cnt == d0) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(done_cnt == d0 + 1, "R9 R10 single done", done_cnt - d0, 1);
      chk(sbq.size() == 0, "R3 all writes seen", sbq.size(), 0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0;
      p1b_in = '0; p2b_in = '0; k1b_in = '0; k2b_in = '0;
      len_in = '0; xr_in = '0; mr_in = '0;
      j_p1b = '0; j_p2b = '0; j_k1b = '0; j_k2b = '0; j_xr = '0; j_mr = '0;
      bal[0] = 0; bal[1] = 0; kid1_word = '0;
      for (int a = 0; a < 256; a++) mem[a] = '0;
      repeat (3) @(negedge clk);
      chk(!rd_en && !wr_en && !done, "R1 reset outputs", {rd_en, wr_en, done}, 0);
      rst_n = 1'b1;

      // J1: plain copy, mixed words (R4, R6)
      for (int w = 0; w < 4; w++) begin
         mem[w]        = DW'(w * 37 + 5);
         mem[8'h20 + w] = DW'(w * 91 + 200);
      end
      run_job(8'h00, 8'h20, 8'h80, 8'hA0, 4, 8'd0, 8'd0, 1'b0);

      // J2: full crossover on complementary parents (R5)
      for (int w = 0; w < 16; w++) begin
         mem[w]        = 8'hFF;
         mem[8'h20 + w] = 8'h00;
      end
      run_job(8'h00, 8'h20, 8'h80, 8'hA0, 16, 8'hFF, 8'd0, 1'b0);
      chk(diff_words > 0, "R5 mask varies", diff_words, 1);

      // J3: intermediate crossover rate, mixed words (R5)
      for (int w = 0; w < 8; w++) begin
         mem[w]        = DW'(w * 53 + 17);
         mem[8'h20 + w] = DW'(w * 29 + 99);
      end
      run_job(8'h00, 8'h20, 8'h80, 8'hA0, 8, 8'd128, 8'd0, 1'b0);

      // J4: forced mutation on uniform parents (R7, R8)
      for (int w = 0; w < 6; w++) begin
         mem[w]        = 8'hFF;
         mem[8'h20 + w] = 8'h00;
      end
      run_job(8'h00, 8'h20, 8'h80, 8'hA0, 6, 8'd0, 8'hFF, 1'b0);

      // J5: balanced single word, t = 0 forbids a flip (R7)
      mem[0] = 8'h0F; mem[8'h20] = 8'hF0;
      run_job(8'h00, 8'h20, 8'h80, 8'hA0, 1, 8'd0, 8'hFF, 1'b0);
      chk(mem[8'h80] == 8'h0F && mem[8'hA0] == 8'hF0, "R7 balanced unchanged",
          {mem[8'h80], mem[8'hA0]}, 16'h0FF0);

      // J6: mixed sequence under forced mutation (R7)
      mem[0] = 8'h0F; mem[1] = 8'hFF; mem[2] = 8'h00;
      mem[8'h20] = 8'hF0; mem[8'h21] = 8'h00; mem[8'h22] = 8'hFF;
      run_job(8'h00, 8'h20, 8'h80, 8'hA0, 3, 8'd0, 8'hFF, 1'b0);

      // J7: empty run (R9)
      run_job(8'h00, 8'h20, 8'h80, 8'hA0, 0, 8'd0, 8'd0, 1'b0);

      // J8: start ignored while busy (R10)
      for (int w = 0; w < 4; w++) begin
         mem[w]        = DW'(w + 8'h31);
         mem[8'h20 + w] = DW'(w + 8'hC4);
      end
      run_job(8'h00, 8'h20, 8'h80, 8'hA0, 4, 8'd0, 8'd0, 1'b1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule